// File: doc/BRIEF.md
# Configuration Word Streaming Sequencer

This block walks through a small configuration image, one 16-bit word per address, and writes each word to a target register port using a valid/acknowledge handshake. It keeps its own 6-bit word address and shows it on `curAddr`. The image memory lives outside the block: `memAddr` selects a word and `memData` returns it in the same cycle. Each time a word write completes, the address moves by one and `addrStrobe` pulses. When the address drops from the last image address back to zero, the whole image has been written. That wrap is the only end-of-image indication.

A pass begins when `startReq` is raised along with a mode code. The mode code is captured and travels with every word write on `wrMode`, which tells the target which kind of reconfiguration the words belong to. A one-cycle `addrClr` pulse sends the address back to zero at any time. If the pulse lands during a write, that write is dropped. A build can turn off mode selection. In that case the mode input is ignored and one fixed mode is used.

Top module: `cfg_word_seq`

## Requirements
- R1: After reset, `curAddr` is 0 and `busy`, `wrValid`, `addrStrobe` and `modeErr` are all low.
- R2: Each write presents `wrAddr` equal to the current word address and `wrData` equal to the memory word at that address. Both are held steady with `wrValid` high until the cycle in which `wrAck` is sampled high.
- R3: In the cycle after an acknowledge, `curAddr` has moved up by exactly one and `addrStrobe` is high for that one cycle. `addrStrobe` is never high while a write is pending.
- R4: Acknowledging the word at the last image address (parameter `LAST_ADDR`, at most 63) returns `curAddr` to 0 with a strobe, and `busy` goes low in that same cycle.
- R5: A one-cycle `addrClr` forces `curAddr` to 0 on the next cycle. If it arrives during a write, the clear wins over any acknowledge: `wrValid` drops, no strobe is produced, and the pass goes on from address 0.
- R6: The 3-bit codes 000 (default), 011 (transmit rate divide), 100 (PLL), 101 (channel plus PLL), 110 (channel with transmit PLL choice) and 111 (central control) start a pass. The accepted code appears on `wrMode` for every write of that pass.
- R7: With `EXT_MODES` set, the mode port is 4 bits wide and codes 1000 to 1011 (the equalization and eye-monitor controls) also start a pass.
- R8: A start carrying an undefined code (001, 010, or 1100 to 1111) is refused. `busy` stays low and `modeErr` is high for exactly the one following cycle.
- R9: With `MULTI_MODE` cleared, `modeSel` is ignored. Every start runs with `FIXED_MODE` and never raises `modeErr`.
- R10: A `startReq` that arrives while `busy` is high has no effect on the pass, on `wrMode` or on `modeErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a pass |
| modeSel | input | MODE_W | Mode code for the pass (3 bits, or 4 with EXT_MODES) |
| addrClr | input | 1 | One-cycle pulse that sends the word address to 0 |
| memAddr | output | 6 | Word address presented to the image memory |
| memData | input | 16 | Image word at memAddr, same cycle |
| wrValid | output | 1 | Target write pending |
| wrAddr | output | 6 | Word address of the pending write |
| wrData | output | 16 | Word being written |
| wrMode | output | MODE_W | Mode tag of the current pass |
| wrAck | input | 1 | Target accepts the pending write |
| curAddr | output | 6 | Current word address |
| addrStrobe | output | 1 | One-cycle pulse after the address moves |
| busy | output | 1 | Pass in progress |
| modeErr | output | 1 | One-cycle pulse when a start is refused |

## Verification
The bench sweeps every code of the 4-bit mode port and varies how long the target waits before acknowledging. A design that decodes modes badly would start a pass on an undefined code, or would fail to tag the writes with the accepted code. A design that wraps at the wrong address, or strobes while a write is still open, is caught by checking `curAddr`, `addrStrobe` and `busy` against an address counted in the bench after every acknowledge. A clear pulse is sent in the middle of an unacknowledged write. A design that let the dropped write still count would show a strobe or a nonzero address. A stray start during a pass and a build with mode selection turned off check that ignored inputs stay ignored.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LOAD  = 2'd1,
    SEQ_WRITE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic stepAddr;
    logic loadWord;
    logic latchMode;
  } seqCtl_t;

  function automatic logic modeLegal(input logic [3:0] code, input logic ext);
    case (code)
      4'd0, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: modeLegal = 1'b1;
      4'd8, 4'd9, 4'd10, 4'd11:           modeLegal = ext;
      default:                            modeLegal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    addrClr,
  input  logic    wrAck,
  input  logic    modeOk,
  input  logic    lastHit,
  output seqCtl_t ctl,
  output logic    wrValid,
  output logic    busy,
  output logic    modeErr
);

  seqState_t state, stateNext;
  logic      errNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    errNext   = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (addrClr) ctl.clrAddr = 1'b1;
        if (startReq) begin
          if (modeOk) begin
            ctl.latchMode = 1'b1;
            stateNext     = SEQ_LOAD;
          end else begin
            errNext = 1'b1;
          end
        end
      end
      SEQ_LOAD: begin
        if (addrClr) begin
          ctl.clrAddr = 1'b1;
        end else begin
          ctl.loadWord = 1'b1;
          stateNext    = SEQ_WRITE;
        end
      end
      SEQ_WRITE: begin
        if (addrClr) begin
          ctl.clrAddr = 1'b1;
          stateNext   = SEQ_LOAD;
        end else if (wrAck) begin
          ctl.stepAddr = 1'b1;
          stateNext    = lastHit ? SEQ_IDLE : SEQ_LOAD;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      modeErr <= 1'b0;
    end else begin
      state   <= stateNext;
      modeErr <= errNext;
    end
  end

  assign wrValid = (state == SEQ_WRITE);
  assign busy    = (state != SEQ_IDLE);

endmodule

// File: rtl/cfg_seq_dpath.sv
module cfg_seq_dpath
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int MODE_W    = 4,
  parameter int LAST_ADDR = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] memData,
  input  logic [MODE_W-1:0] effMode,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastHit,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [MODE_W-1:0] wrMode,
  output logic              addrStrobe
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  assign lastHit = (curAddr == LAST_A);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr    <= '0;
      addrStrobe <= 1'b0;
    end else begin
      addrStrobe <= ctl.stepAddr;
      if (ctl.clrAddr)       curAddr <= '0;
      else if (ctl.stepAddr) curAddr <= lastHit ? '0 : curAddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrData <= '0;
      wrMode <= '0;
    end else begin
      if (ctl.loadWord) begin
        wrAddr <= curAddr;
        wrData <= memData;
      end
      if (ctl.latchMode) wrMode <= effMode;
    end
  end

endmodule

// File: rtl/cfg_word_seq.sv
module cfg_word_seq
  import cfg_seq_pkg::*;
#(
  parameter bit         EXT_MODES  = 1'b1,
  parameter bit         MULTI_MODE = 1'b1,
  parameter logic [3:0] FIXED_MODE = 4'd0,
  parameter int         LAST_ADDR  = 7,
  localparam int        ADDR_W     = 6,
  localparam int        DATA_W     = 16,
  localparam int        MODE_W     = EXT_MODES ? 4 : 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              addrClr,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [MODE_W-1:0] wrMode,
  input  logic              wrAck,
  output logic [ADDR_W-1:0] curAddr,
  output logic              addrStrobe,
  output logic              busy,
  output logic              modeErr
);

  seqCtl_t           ctl;
  logic              lastHit;
  logic              modeOk;
  logic [MODE_W-1:0] effMode;

  generate
    if (MULTI_MODE) begin : g_sel
      assign effMode = modeSel;
      assign modeOk  = modeLegal(4'(modeSel), EXT_MODES);
    end else begin : g_fixed
      logic unusedSel;
      assign unusedSel = ^modeSel;
      assign effMode   = MODE_W'(FIXED_MODE);
      assign modeOk    = 1'b1;
    end
  endgenerate

  cfg_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .addrClr(addrClr),
    .wrAck(wrAck), .modeOk(modeOk), .lastHit(lastHit), .ctl(ctl),
    .wrValid(wrValid), .busy(busy), .modeErr(modeErr)
  );

  cfg_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .LAST_ADDR(LAST_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memData(memData), .effMode(effMode),
    .curAddr(curAddr), .lastHit(lastHit), .wrAddr(wrAddr), .wrData(wrData),
    .wrMode(wrMode), .addrStrobe(addrStrobe)
  );

  assign memAddr = curAddr;

endmodule

// File: rtl/cfg_word_seq_chk.sv
module cfg_word_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        addrClr,
  input logic        wrAck,
  input logic        wrValid,
  input logic [5:0]  wrAddr,
  input logic [15:0] wrData,
  input logic [5:0]  curAddr,
  input logic        addrStrobe,
  input logic        busy,
  input logic        modeErr
);

  // R2
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrAck && !addrClr) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R3
  no_strobe_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |-> !wrValid);

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && curAddr != 6'd0) |-> (curAddr == $past(curAddr) + 6'd1));

  // R4
  wrap_ends_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && curAddr == 6'd0) |-> !busy);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrClr |=> (curAddr == 6'd0 && !addrStrobe));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> (!busy && !$past(modeErr)));

endmodule

bind cfg_word_seq cfg_word_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .addrClr(addrClr), .wrAck(wrAck),
  .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .curAddr(curAddr),
  .addrStrobe(addrStrobe), .busy(busy), .modeErr(modeErr)
);

// File: tb/test_cfg_word_seq.sv
module test_cfg_word_seq;

  localparam int LAST = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [3:0]  modeSel = 4'd0;
  logic        addrClr = 1'b0;
  logic        wrAck = 1'b0;
  logic [5:0]  memAddr, wrAddr, curAddr;
  logic [15:0] memData, wrData;
  logic [3:0]  wrMode;
  logic        wrValid, addrStrobe, busy, modeErr;

  logic [5:0]  memAddr2, wrAddr2, curAddr2;
  logic [15:0] memData2, wrData2;
  logic [3:0]  wrMode2;
  logic        wrValid2, addrStrobe2, busy2, modeErr2;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] dataOf(input logic [5:0] a);
    dataOf = (16'(a) * 16'h2F1B) ^ 16'h5A3C;
  endfunction

  assign memData  = dataOf(memAddr);
  assign memData2 = dataOf(memAddr2);

  cfg_word_seq #(.EXT_MODES(1'b1), .MULTI_MODE(1'b1), .LAST_ADDR(LAST)) i_cfg_word_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeSel(modeSel), .addrClr(addrClr),
    .memAddr(memAddr), .memData(memData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrMode(wrMode), .wrAck(wrAck), .curAddr(curAddr),
    .addrStrobe(addrStrobe), .busy(busy), .modeErr(modeErr)
  );

  // build with mode selection off, fixed mode 1001, target acks at once
  cfg_word_seq #(.EXT_MODES(1'b1), .MULTI_MODE(1'b0), .FIXED_MODE(4'd9), .LAST_ADDR(LAST)) i_cfg_word_seq_fixed (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeSel(modeSel), .addrClr(1'b0),
    .memAddr(memAddr2), .memData(memData2), .wrValid(wrValid2), .wrAddr(wrAddr2),
    .wrData(wrData2), .wrMode(wrMode2), .wrAck(wrValid2), .curAddr(curAddr2),
    .addrStrobe(addrStrobe2), .busy(busy2), .modeErr(modeErr2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit legal(input int m);
    legal = (m == 0) || (m >= 3 && m <= 11);
  endfunction

  task automatic runPass(input int mode, input int dly, input int clrAt, input bit stray);
    int a = 0;
    bit cleared = 1'b0;
    modeSel = 4'(mode);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1 && modeErr == 1'b0, "R6/R7 start accepted", busy, 1);
    forever begin
      for (int g = 0; g < 20 && !wrValid; g++) @(negedge clk);
      check(wrAddr == 6'(a), "R2 write address", wrAddr, a);
      check(wrData == dataOf(6'(a)), "R2 write data", wrData, dataOf(6'(a)));
      check(wrMode == 4'(mode), "R6 mode tag", wrMode, mode);
      check(addrStrobe == 1'b0, "R3 no strobe while pending", addrStrobe, 0);
      if (!cleared && a == clrAt) begin
        addrClr = 1'b1;
        wrAck = 1'b1;
        @(negedge clk);
        addrClr = 1'b0;
        wrAck = 1'b0;
        check(curAddr == 6'd0, "R5 clear address", curAddr, 0);
        check(wrValid == 1'b0 && addrStrobe == 1'b0, "R5 write dropped", {wrValid, addrStrobe}, 0);
        cleared = 1'b1;
        a = 0;
        continue;
      end
      if (stray && a == 1) begin
        modeSel = 4'd1;
        startReq = 1'b1;
      end
      for (int h = 0; h < dly; h++) begin
        @(negedge clk);
        startReq = 1'b0;
        check(wrValid && wrAddr == 6'(a) && wrData == dataOf(6'(a)), "R2 hold until ack", wrAddr, a);
        if (stray && a == 1)
          check(modeErr == 1'b0 && wrMode == 4'(mode), "R10 start while busy", wrMode, mode);
      end
      wrAck = 1'b1;
      @(negedge clk);
      wrAck = 1'b0;
      check(addrStrobe == 1'b1, "R3 strobe after ack", addrStrobe, 1);
      if (a == LAST) begin
        check(curAddr == 6'd0, "R4 wrap to zero", curAddr, 0);
        check(busy == 1'b0, "R4 busy drops at wrap", busy, 0);
        break;
      end
      check(curAddr == 6'(a + 1), "R3 step by one", curAddr, a + 1);
      a++;
    end
    @(negedge clk);
    check(addrStrobe == 1'b0 && busy == 1'b0, "R3 strobe single cycle", addrStrobe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(curAddr == 6'd0 && busy == 1'b0 && wrValid == 1'b0, "R1 reset state", curAddr, 0);
    check(addrStrobe == 1'b0 && modeErr == 1'b0, "R1 reset strobes", {addrStrobe, modeErr}, 0);

    // R9: fixed build ignores an undefined code on modeSel
    modeSel = 4'd2;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy2 == 1'b1 && modeErr2 == 1'b0, "R9 fixed build starts", busy2, 1);
    check(modeErr == 1'b1 && busy == 1'b0, "R8 code 0010 refused", modeErr, 1);
    for (int g = 0; g < 10 && !wrValid2; g++) @(negedge clk);
    check(wrMode2 == 4'd9, "R9 fixed mode used", wrMode2, 9);
    for (int g = 0; g < 60 && busy2; g++) @(negedge clk);
    check(busy2 == 1'b0 && curAddr2 == 6'd0, "R9 fixed pass completes", curAddr2, 0);

    // R6 R7 R8: sweep every 4-bit code
    for (int m = 0; m < 16; m++) begin
      if (legal(m)) begin
        runPass(m, m % 3, -1, 1'b0);
      end else begin
        modeSel = 4'(m);
        startReq = 1'b1;
        @(negedge clk);
        startReq = 1'b0;
        check(modeErr == 1'b1 && busy == 1'b0, "R8 undefined code refused", modeErr, 1);
        @(negedge clk);
        check(modeErr == 1'b0 && busy == 1'b0, "R8 error single cycle", modeErr, 0);
      end
      for (int g = 0; g < 60 && busy2; g++) @(negedge clk);
    end

    // R5: clear during the write of word 3
    runPass(5, 1, 3, 1'b0);
    // R10: stray start during the pass
    runPass(4, 2, -1, 1'b1);
    // R5: clear while idle keeps the address at zero
    addrClr = 1'b1;
    @(negedge clk);
    addrClr = 1'b0;
    check(curAddr == 6'd0 && addrStrobe == 1'b0, "R5 clear while idle", curAddr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule